// File: doc/BRIEF.md
# Linked Instruction Breakpoint Match Unit

This unit holds a small bank of breakpoint pairs. Each pair has a 32-bit value register and a control register. Every cycle, it compares each enabled pair with the instruction fetch on its inputs. A fetch is described by its virtual address, the byte lanes it touches, the current context ID, the security state and a processor mode class. When at least one pair hits a valid fetch, the unit raises a debug-event flag one cycle later, together with the number of the lowest-numbered pair that hit.

Software programs the pairs through a plain register port. The port takes a write strobe, a pair index and a value/control select, and it returns read data combinationally. A pair can compare the fetch address for a match or for a mismatch. It can also compare the context ID. An address pair may name a partner pair that supplies a context-ID qualification. Only the upper pairs (4 and 5 by default) can hold context-ID modes.

Top module: `brk_pair_bank`

## Requirements
- R1: After reset every value and control register reads 0. A pair whose control bit 0 is 0 never causes an event.
- R2: Only control bits [22:14], [8:5], [2:1] and [0] are stored. Every other control bit reads 0 and ignores writes. Value registers store all 32 bits.
- R3: On pairs 0 to 3, control bit 21 always reads 0 and cannot be set. A written mode therefore loses bit 21.
- R4: In the address modes, value bits [31:2] are compared with fetch address bits [31:2]. Address bits [1:0] do not take part.
- R5: Control bits [8:5] are the byte-lane select. Bit 5+k stands for byte k of the word. An address compare succeeds only if the address bits are equal and at least one selected lane is set in the fetch lane mask.
- R6: Mode field [22:20] = 100 (mismatch) hits exactly when the address compare of R4/R5 fails. Mode 101 does the same and also requires the link of R8.
- R7: Mode 010 hits when all 32 value bits equal the fetch context ID.
- R8: Modes 001 and 101 name a partner in control bits [19:16]. The link holds only when the partner exists, is not the pair itself, is enabled, is in mode 011, and has a value equal to the context ID. Otherwise the pair never hits.
- R9: Mode 011 never causes an event by itself. Modes 110 and 111 never hit.
- R10: Security field [15:14]: 00 matches in both states, 01 only when fetch_secure=0, 10 only when fetch_secure=1, 11 never.
- R11: Mode class input: 00 User, 01 System, 10 Supervisor, 11 other privileged. Mode field [2:1]: 00 matches classes 00/01/10, 01 matches any class except 00, 10 matches only 00, 11 matches all.
- R12: A pair is compared only while fetch_valid is 1. dbg_event reflects the fetch of the previous clock cycle.
- R13: dbg_index gives the lowest-numbered hitting pair. It is 0 when dbg_event is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel_ctl | input | 1 | 1 selects the control register, 0 selects the value register |
| reg_idx | input | IW | Pair number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_addr | input | 32 | Fetch virtual address |
| fetch_lanes | input | 4 | Byte lanes of the word touched by the fetch |
| fetch_ctxid | input | 32 | Current context ID |
| fetch_secure | input | 1 | 1 when in Secure state |
| fetch_pmode | input | 2 | Processor mode class |
| dbg_event | output | 1 | Registered debug event |
| dbg_index | output | IW | Lowest hitting pair number |

## Verification
The bench targets several corner cases:
- Linked pairs whose partner is the pair itself, out of range, disabled, or in the wrong mode. A design that skipped any of these tests would fire where no context match exists.
- A mismatch pair with an empty lane select. This must hit everywhere, so a design that treated "never hits" as absolute for mismatch would stay silent.
- Control writes with every bit set. These catch a design that stores reserved bits, or that lets a low pair take a context-ID mode.
- Priority when several pairs hit together. A wrong encoder would report a higher pair.
- Fetches that would hit but arrive with fetch_valid low. A design that ignores the strobe would fire on them.

// File: rtl/brk_pair_bank.sv
module brk_pair_bank #(
  parameter int NPAIRS    = 6,
  parameter int CTX_FIRST = 4,
  localparam int IW = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel_ctl,
  input  logic [IW-1:0] reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_addr,
  input  logic [3:0]    fetch_lanes,
  input  logic [31:0]   fetch_ctxid,
  input  logic          fetch_secure,
  input  logic [1:0]    fetch_pmode,
  output logic          dbg_event,
  output logic [IW-1:0] dbg_index
);
  localparam logic [31:0] KEEP_CTX   = 32'h007F_C1E7;
  localparam logic [31:0] KEEP_NOCTX = KEEP_CTX & ~32'h0020_0000;

  logic [31:0]       val_q [NPAIRS];
  logic [31:0]       ctl_q [NPAIRS];
  logic [NPAIRS-1:0] en, prov, ctx_eq, hit;

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    localparam logic [31:0] KEEP = (i >= CTX_FIRST) ? KEEP_CTX : KEEP_NOCTX;
    logic       sec_ok, pm_ok, addr_ok, link_ok, base;
    logic [2:0] md;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[i] <= '0;
        ctl_q[i] <= '0;
      end else if (reg_we && reg_idx == IW'(i)) begin
        if (reg_sel_ctl) ctl_q[i] <= reg_wdata & KEEP;
        else             val_q[i] <= reg_wdata;
      end
    end

    assign md        = ctl_q[i][22:20];
    assign en[i]     = ctl_q[i][0];
    assign ctx_eq[i] = (val_q[i] == fetch_ctxid);
    assign prov[i]   = en[i] && md == 3'b011;
    assign addr_ok   = (val_q[i][31:2] == fetch_addr[31:2]) && |(ctl_q[i][8:5] & fetch_lanes);

    always_comb begin
      case (ctl_q[i][15:14])
        2'b00:   sec_ok = 1'b1;
        2'b01:   sec_ok = !fetch_secure;
        2'b10:   sec_ok = fetch_secure;
        default: sec_ok = 1'b0;
      endcase
      case (ctl_q[i][2:1])
        2'b00:   pm_ok = fetch_pmode != 2'b11;
        2'b01:   pm_ok = fetch_pmode != 2'b00;
        2'b10:   pm_ok = fetch_pmode == 2'b00;
        default: pm_ok = 1'b1;
      endcase
      link_ok = 1'b0;
      for (int j = 0; j < NPAIRS; j++)
        if (j != i && ctl_q[i][19:16] == 4'(j)) link_ok = prov[j] && ctx_eq[j];
      case (md)
        3'b000:  base = addr_ok;
        3'b001:  base = addr_ok && link_ok;
        3'b010:  base = ctx_eq[i];
        3'b100:  base = !addr_ok;
        3'b101:  base = !addr_ok && link_ok;
        default: base = 1'b0;
      endcase
    end

    assign hit[i] = fetch_valid && en[i] && sec_ok && pm_ok && base;
  end

  logic [IW-1:0] first;
  always_comb begin
    first = '0;
    for (int k = NPAIRS - 1; k >= 0; k--)
      if (hit[k]) first = IW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_event <= 1'b0;
      dbg_index <= '0;
    end else begin
      dbg_event <= |hit;
      dbg_index <= (|hit) ? first : '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NPAIRS; k++)
      if (reg_idx == IW'(k)) reg_rdata = reg_sel_ctl ? ctl_q[k] : val_q[k];
  end

  // R12
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !dbg_event);
  // R13
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> (dbg_index < IW'(NPAIRS)));
  // R13
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_event |-> (dbg_index == '0));
  // R1
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !dbg_event);
  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel_ctl |-> ((reg_rdata & ~KEEP_CTX) == '0));
endmodule

// File: tb/sim_brk_pair_bank.sv
module sim_brk_pair_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int CF = 4;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, reg_sel_ctl = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fetch_valid = 0, fetch_secure = 0;
  logic [31:0] fetch_addr = 0, fetch_ctxid = 0;
  logic [3:0]  fetch_lanes = 0;
  logic [1:0]  fetch_pmode = 0;
  logic        dbg_event;
  logic [2:0]  dbg_index;

  int vecs = 0, bad = 0;
  bit done = 0;
  logic [31:0] mval [NP];
  logic [31:0] mctl [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_pair_bank #(.NPAIRS(NP), .CTX_FIRST(CF)) u0 (
    .clk, .rst_n, .reg_we, .reg_sel_ctl, .reg_idx, .reg_wdata, .reg_rdata,
    .fetch_valid, .fetch_addr, .fetch_lanes, .fetch_ctxid, .fetch_secure,
    .fetch_pmode, .dbg_event, .dbg_index);

  function automatic logic [31:0] keep(int i);
    logic [31:0] k = 32'h007F_C1E7;
    if (i < CF) k[21] = 1'b0;
    return k;
  endfunction

  function automatic logic [31:0] mk(bit e, logic [2:0] md, logic [3:0] lk,
                                     logic [1:0] sec, logic [3:0] bas, logic [1:0] pm);
    return {9'd0, md, lk, sec, 5'd0, bas, 2'd0, pm, e};
  endfunction

  function automatic bit addr_cmp(int i);
    return mval[i][31:2] == fetch_addr[31:2] && (mctl[i][8:5] & fetch_lanes) != 0;
  endfunction

  function automatic bit pair_hits(int i);
    logic [31:0] c = mctl[i];
    bit s_ok, p_ok, lnk;
    int p = int'(c[19:16]);
    if (!fetch_valid || !c[0]) return 0;
    s_ok = c[15:14] == 0 || (c[15:14] == 1 && !fetch_secure) || (c[15:14] == 2 && fetch_secure);
    p_ok = c[2:1] == 3 || (c[2:1] == 0 && fetch_pmode != 3) ||
           (c[2:1] == 1 && fetch_pmode != 0) || (c[2:1] == 2 && fetch_pmode == 0);
    lnk = p < NP && p != i && mctl[p][0] && mctl[p][22:20] == 3'b011 && mval[p] == fetch_ctxid;
    if (!s_ok || !p_ok) return 0;
    case (c[22:20])
      3'b000: return addr_cmp(i);
      3'b001: return addr_cmp(i) && lnk;
      3'b010: return mval[i] == fetch_ctxid;
      3'b100: return !addr_cmp(i);
      3'b101: return !addr_cmp(i) && lnk;
      default: return 0;
    endcase
  endfunction

  task automatic wr(int i, bit sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel_ctl = sel; reg_idx = 3'(i); reg_wdata = d;
    if (sel) mctl[i] = d & keep(i); else mval[i] = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd_chk(int i, bit sel, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_sel_ctl = sel; reg_idx = 3'(i); #1;
    vecs++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: pair %0d sel %0b read %h expected %h", tag, i, sel, reg_rdata, exp);
    end
  endtask

  task automatic fetch(logic [31:0] a, logic [3:0] ln, logic [31:0] cx, bit s,
                       logic [1:0] pm, bit v, string tag);
    bit ee = 0;
    logic [2:0] ei = 0;
    @(negedge clk);
    fetch_valid = v; fetch_addr = a; fetch_lanes = ln; fetch_ctxid = cx;
    fetch_secure = s; fetch_pmode = pm;
    for (int k = NP - 1; k >= 0; k--)
      if (pair_hits(k)) begin ee = 1; ei = 3'(k); end
    @(posedge clk); #1;
    fetch_valid = 0;
    vecs++;
    if (dbg_event !== ee || dbg_index !== ei) begin
      bad++;
      $display("FAIL %s: event/index %0b/%0d expected %0b/%0d", tag, dbg_event, dbg_index, ee, ei);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [4];
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1004;
    pool[2] = 32'h0000_00A5; pool[3] = 32'h5A5A_0000;
    void'($urandom(32'd2024));
    for (int i = 0; i < NP; i++) begin mval[i] = 0; mctl[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int i = 0; i < NP; i++) begin
      rd_chk(i, 1, 32'h0, "R1 reset ctl");
      rd_chk(i, 0, 32'h0, "R1 reset val");
    end
    fetch(32'h0, 4'hF, 32'h0, 0, 0, 1, "R1 all disabled");

    wr(5, 1, 32'hFFFF_FFFF);
    rd_chk(5, 1, 32'h007F_C1E7, "R2 reserved bits");
    wr(0, 1, 32'hFFFF_FFFF);
    rd_chk(0, 1, 32'h005F_C1E7, "R3 no ctx bit");
    wr(5, 0, 32'hDEAD_BEEF);
    rd_chk(5, 0, 32'hDEAD_BEEF, "R2 value full width");
    wr(0, 1, 0); wr(5, 1, 0);
    wr(2, 1, mk(0, 3'b100, 0, 0, 4'hF, 3));
    rd_chk(2, 1, mk(0, 3'b100, 0, 0, 4'hF, 3), "R2 field readback");
    fetch(32'h7000, 4'hF, 0, 0, 0, 1, "R1 disabled mismatch");

    wr(1, 0, 32'h0000_1003);
    wr(1, 1, mk(1, 3'b000, 0, 0, 4'h3, 3));
    fetch(32'h0000_1002, 4'h1, 0, 0, 0, 1, "R4 low bits ignored");
    fetch(32'h0000_1000, 4'h4, 0, 0, 0, 1, "R5 lane miss");
    fetch(32'h0000_1000, 4'h2, 0, 0, 0, 1, "R5 lane hit");
    fetch(32'h0000_1004, 4'hF, 0, 0, 0, 1, "R4 word miss");
    wr(0, 0, 32'h0000_1000);
    wr(0, 1, mk(1, 3'b000, 0, 0, 4'hC, 3));
    fetch(32'h0000_1000, 4'hF, 0, 0, 0, 1, "R13 lowest wins");
    wr(0, 1, 0);

    wr(2, 0, 32'h0000_1000);
    wr(2, 1, mk(1, 3'b100, 0, 0, 4'hF, 3));
    fetch(32'h0000_1000, 4'h1, 0, 0, 0, 1, "R6 mismatch silent on match");
    fetch(32'h0000_2000, 4'h1, 0, 0, 0, 1, "R6 mismatch hit");
    wr(2, 1, mk(1, 3'b100, 0, 0, 4'h0, 3));
    fetch(32'h0000_1000, 4'h1, 0, 0, 0, 1, "R6 empty lanes always mismatch");
    wr(2, 1, 0); wr(1, 1, 0);

    wr(4, 0, 32'h0000_00A5);
    wr(4, 1, mk(1, 3'b011, 0, 0, 4'hF, 3));
    fetch(32'h0000_00A4, 4'hF, 32'hA5, 0, 0, 1, "R9 provider alone");
    wr(3, 0, 32'h0000_3000);
    wr(3, 1, mk(1, 3'b001, 4, 0, 4'hF, 3));
    fetch(32'h0000_3000, 4'hF, 32'hA5, 0, 0, 1, "R8 linked hit");
    fetch(32'h0000_3000, 4'hF, 32'h5A, 0, 0, 1, "R8 ctx differs");
    wr(3, 1, mk(1, 3'b001, 3, 0, 4'hF, 3));
    fetch(32'h0000_3000, 4'hF, 32'hA5, 0, 0, 1, "R8 self link");
    wr(3, 1, mk(1, 3'b001, 9, 0, 4'hF, 3));
    fetch(32'h0000_3000, 4'hF, 32'hA5, 0, 0, 1, "R8 link out of range");
    wr(4, 1, mk(0, 3'b011, 0, 0, 4'hF, 3));
    wr(3, 1, mk(1, 3'b001, 4, 0, 4'hF, 3));
    fetch(32'h0000_3000, 4'hF, 32'hA5, 0, 0, 1, "R8 partner disabled");
    wr(3, 1, 0); wr(4, 1, 0);

    wr(5, 0, 32'h0000_00A5);
    wr(5, 1, mk(1, 3'b010, 0, 1, 4'hF, 3));
    fetch(32'h0, 4'hF, 32'hA5, 1, 0, 1, "R10 nonsecure only, secure fetch");
    fetch(32'h0, 4'hF, 32'hA5, 0, 0, 1, "R7 ctx hit");
    fetch(32'h0, 4'hF, 32'h1A5, 0, 0, 1, "R7 full width compare");
    wr(5, 1, mk(1, 3'b010, 0, 3, 4'hF, 3));
    fetch(32'h0, 4'hF, 32'hA5, 0, 0, 1, "R10 reserved security");
    wr(5, 1, mk(1, 3'b010, 0, 0, 4'hF, 2));
    fetch(32'h0, 4'hF, 32'hA5, 0, 1, 1, "R11 user only, system fetch");
    fetch(32'h0, 4'hF, 32'hA5, 0, 0, 1, "R11 user only, user fetch");
    wr(5, 1, mk(1, 3'b010, 0, 0, 4'hF, 0));
    fetch(32'h0, 4'hF, 32'hA5, 0, 3, 1, "R11 usr/sys/svc class other");
    fetch(32'h0, 4'hF, 32'hA5, 0, 0, 0, "R12 valid low");
    wr(5, 1, mk(1, 3'b110, 0, 0, 4'hF, 3));
    fetch(32'h0, 4'hF, 32'hA5, 0, 0, 1, "R9 reserved mode");

    for (int n = 0; n < 1500; n++) begin
      if (n % 6 == 0) begin
        int i = $urandom % NP;
        logic [3:0] bas;
        case ($urandom % 5) 0: bas = 0; 1: bas = 3; 2: bas = 4'hC; 3: bas = 4'hF; default: bas = 4'($urandom); endcase
        wr(i, 0, pool[$urandom % 4]);
        wr(i, 1, mk(($urandom % 4) != 0, 3'($urandom), 4'($urandom % 8), 2'($urandom % 4 == 0 ? 3 : $urandom % 3),
                    bas, 2'($urandom)) | ($urandom & 32'hE380_1E18));
      end
      fetch(pool[$urandom % 2] | 32'($urandom % 4), 4'($urandom), pool[2 + $urandom % 2],
            1'($urandom), 2'($urandom), ($urandom % 8) != 0, "R13 random mix");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule